// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

This block is a free-running up-counter of twice the bus width (64 bits by default) with a comparator of the same width. Both are accessed through a small 32-bit register bus with address, write enable, write data and combinational read data. The counter advances by one on every clock where the timer is enabled and the tick strobe input is high. Software reads the count as two halves. Because the count keeps moving between the two reads, software reads the upper half, then the lower half, then the upper half again, and retries when the two upper values differ.

When the comparator is enabled and the count equals the compare value, a compare event occurs. The event sets a sticky pending flag that software clears by writing one to it. If interrupts are enabled, the event also produces a one-cycle interrupt pulse. With auto-increment on, each event adds a programmable step to the compare value, which gives periodic ticks. The compare value can only be rewritten while the comparator is disabled.

Top module: `gtmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The count register (low half at byte offset 0x00, high half at 0x04) advances by exactly one on each clock where control bit 0 (timer enable) and `tick` are both high. On every other clock it holds.
- R3: The count is 2*DATA_W bits wide, and the low half carries into the high half.
- R4: The control register at offset 0x08 stores write-data bits 3:0 (bit 0 timer, bit 1 comparator, bit 2 interrupt, bit 3 auto-increment) and reads higher bits as zero.
- R5: A compare event occurs when control bit 1 is set and count equals compare. It sets status bit 0 (offset 0x0C) on the next clock edge, whatever the value of control bit 2.
- R6: Each compare event drives `irq` high for exactly one cycle, beginning the cycle after the event, and only when control bit 2 is set. A count that stays equal to the compare value gives one event, not a stream of them.
- R7: Writing status with bit 0 set clears the pending flag. Writing status with bit 0 clear leaves it unchanged.
- R8: Writes to compare low (0x10) and compare high (0x14) take effect only while control bit 1 is clear. While it is set, such writes are ignored.
- R9: When control bit 3 is set, each compare event adds the auto-increment step (offset 0x18, zero-extended) to the full-width compare value, with carry into the high half.
- R10: While control bit 1 is clear, no event occurs and the pending flag is not set, even when count equals compare.
- R11: Reads from unmapped offsets return zero, and writes to the count offsets do not change the count.
- R12: The count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe; the counter advances on clocks where it is high |
| addr | input | ADDR_W | Byte offset of the register access |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | One-cycle compare interrupt pulse |

## Verification
Register writes take effect at the clock edge they straddle, and read data is combinational. The bench therefore drives at the falling edge and samples one falling edge after a write or tick burst. A compare event is seen at the edge where count equals compare. Its pending flag and `irq` pulse become visible one cycle after that edge, so the bench idles a few cycles after each burst before it reads status or counts the interrupt pulses seen at falling edges. Every expected count, compare value and pulse total is computed from the number of ticks driven and the programmed step.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  // register byte offsets
  localparam int OFF_CNT_LO = 'h00;
  localparam int OFF_CNT_HI = 'h04;
  localparam int OFF_CTL    = 'h08;
  localparam int OFF_STAT   = 'h0C;
  localparam int OFF_CMP_LO = 'h10;
  localparam int OFF_CMP_HI = 'h14;
  localparam int OFF_STEP   = 'h18;

  // control bit positions
  localparam int CTL_W    = 4;
  localparam int BIT_TMR  = 0;
  localparam int BIT_CMP  = 1;
  localparam int BIT_INT  = 2;
  localparam int BIT_AUTO = 3;

  typedef struct packed {
    logic cntEn;
    logic wrCmpLo;
    logic wrCmpHi;
    logic wrStep;
    logic addStep;
  } gtStrobes_t;
endpackage

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gtStrobes_t            strb,
  input  logic [DATA_W-1:0]     wrData,
  output logic [2*DATA_W-1:0]   cnt,
  output logic [2*DATA_W-1:0]   cmp,
  output logic [DATA_W-1:0]     step
);
  localparam int CNT_W = 2 * DATA_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      cmp  <= '0;
      step <= '0;
    end else begin
      if (strb.cntEn) cnt <= cnt + CNT_W'(1);
      if (strb.wrStep) step <= wrData;
      if (strb.addStep) begin
        cmp <= cmp + CNT_W'(step);
      end else begin
        if (strb.wrCmpLo) cmp[DATA_W-1:0]     <= wrData;
        if (strb.wrCmpHi) cmp[CNT_W-1:DATA_W] <= wrData;
      end
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntEn |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntEn |=> cnt == $past(cnt) + CNT_W'(1));
  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrCmpLo || strb.wrCmpHi || strb.addStep) |=> $stable(cmp));
endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [2*DATA_W-1:0]   cnt,
  input  logic [2*DATA_W-1:0]   cmp,
  input  logic [DATA_W-1:0]     step,
  output gtStrobes_t            strb,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CTL_W-1:0] ctl;
  logic             pending;
  logic             fired;
  logic             matchNow;
  logic             eventNow;
  logic             cmpMoved;
  logic             statClr;

  function automatic logic hit(input int off);
    return addr == ADDR_W'(off);
  endfunction

  always_comb begin
    matchNow      = ctl[BIT_CMP] && (cnt == cmp);
    eventNow      = matchNow && !fired;
    strb.cntEn    = ctl[BIT_TMR] && tick;
    strb.wrCmpLo  = wrEn && hit(OFF_CMP_LO) && !ctl[BIT_CMP];
    strb.wrCmpHi  = wrEn && hit(OFF_CMP_HI) && !ctl[BIT_CMP];
    strb.wrStep   = wrEn && hit(OFF_STEP);
    strb.addStep  = eventNow && ctl[BIT_AUTO];
    cmpMoved      = strb.wrCmpLo || strb.wrCmpHi ||
                    (strb.addStep && (step != '0));
    statClr       = wrEn && hit(OFF_STAT) && wrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl     <= '0;
      pending <= 1'b0;
      fired   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wrEn && hit(OFF_CTL)) ctl <= wrData[CTL_W-1:0];
      if (eventNow)     pending <= 1'b1;
      else if (statClr) pending <= 1'b0;
      fired <= (eventNow || fired) && !strb.cntEn && !cmpMoved;
      irq   <= eventNow && ctl[BIT_INT];
    end
  end

  always_comb begin
    rdData = '0;
    if (hit(OFF_CNT_LO))      rdData = cnt[DATA_W-1:0];
    else if (hit(OFF_CNT_HI)) rdData = cnt[CNT_W-1:DATA_W];
    else if (hit(OFF_CTL))    rdData = DATA_W'(ctl);
    else if (hit(OFF_STAT))   rdData = DATA_W'(pending);
    else if (hit(OFF_CMP_LO)) rdData = cmp[DATA_W-1:0];
    else if (hit(OFF_CMP_HI)) rdData = cmp[CNT_W-1:DATA_W];
    else if (hit(OFF_STEP))   rdData = step;
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(ctl[BIT_INT] && ctl[BIT_CMP]));
  // R5
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pending);
  // R10
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(ctl[BIT_CMP]));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  gtStrobes_t        strb;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [DATA_W-1:0] step;

  gtmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .cnt(cnt), .cmp(cmp), .step(step), .strb(strb),
    .rdData(rdData), .irq(irq)
  );

  gtmr_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .cmp(cmp), .step(step)
  );
endmodule

// File: tb/sim_gtmr_top.sv
`timescale 1ns/1ps
module sim_gtmr_top;
  localparam int DW = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;

  always #2 clk = ~clk;

  gtmr_top #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always @(negedge clk) if (irq === 1'b1) irqSeen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wrData = DW'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a);
    #1;
    d = int'(rdData);
  endtask

  task automatic runTicks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int base;
    doReset();
    // R1 reset state
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(a, v); check("R1", v, 0);
    end
    check("R1 irq", int'(irq), 0);

    // R4 control readback
    wr('h08, 'hFF); rd('h08, v); check("R4", v, 'h0F);
    wr('h08, 0);

    // R2 timer disabled: ticks ignored
    runTicks(5); rd('h00, v); check("R2 off", v, 0);
    wr('h08, 1);
    runTicks(7); rd('h00, v); check("R2 run", v, 7);
    runTicks(2); idle(3); runTicks(4);
    rd('h00, v); check("R2 gaps", v, 13);
    // R11 count write ignored, unmapped read zero
    wr('h00, 'h55); rd('h00, v); check("R11 cnt write", v, 13);
    wr('h1C, 'h33); rd('h1C, v); check("R11 unmapped", v, 0);

    // R3 carry into high half
    doReset(); wr('h08, 1); runTicks(300);
    rd('h00, v); check("R3 lo", v, 44);
    rd('h04, v); check("R3 hi", v, 1);

    // R10 comparator off with count == compare (both 0)
    doReset(); wr('h08, 'h4); idle(3);
    rd('h0C, v); check("R10 status", v, 0);
    // R8 compare writable while comparator off, ignored while on
    wr('h10, 9); rd('h10, v); check("R8 write", v, 9);
    wr('h08, 'h6); wr('h10, 3); wr('h14, 2);
    rd('h10, v); check("R8 lo ignored", v, 9);
    rd('h14, v); check("R8 hi ignored", v, 0);

    // R5 pending without interrupt enable
    base = irqSeen;
    wr('h08, 'h3); runTicks(9); idle(3);
    rd('h0C, v); check("R5 pending", v, 1);
    check("R5 no irq", irqSeen - base, 0);
    // R7 write-one-to-clear
    wr('h0C, 0); rd('h0C, v); check("R7 zero write", v, 1);
    wr('h0C, 1); rd('h0C, v); check("R7 clear", v, 0);
    idle(3); rd('h0C, v); check("R6 no refire", v, 0);

    // R6 single pulse while count held at compare
    wr('h08, 'h1); wr('h10, 12);
    base = irqSeen;
    wr('h08, 'h7); runTicks(3); idle(6);
    check("R6 one pulse", irqSeen - base, 1);
    rd('h0C, v); check("R6 pending", v, 1);

    // R9 periodic sweep over small steps
    for (int s = 1; s <= 6; s++) begin
      doReset();
      wr('h18, s); wr('h10, s);
      base = irqSeen;
      wr('h08, 'hF); runTicks(50); idle(3);
      check("R9 irq count", irqSeen - base, 50 / s);
      rd('h10, v); check("R9 cmp", v, s * (50 / s + 1));
    end
    // R9 compare carry into high half
    doReset();
    wr('h18, 200); wr('h10, 200); wr('h08, 'hB);
    runTicks(200); idle(2);
    rd('h10, v); check("R9 carry lo", v, 'h90);
    rd('h14, v); check("R9 carry hi", v, 1);

    // R12 wrap
    doReset(); wr('h08, 1); runTicks(65535);
    rd('h00, v); check("R12 max lo", v, 'hFF);
    rd('h04, v); check("R12 max hi", v, 'hFF);
    runTicks(1);
    rd('h00, v); check("R12 wrap lo", v, 0);
    rd('h04, v); check("R12 wrap hi", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule